// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This peripheral sits on a processor's load/store bus. It links the processor to a keyboard source and to a display sink. Four word registers lie at consecutive word offsets from a base address. Two belong to the receive channel: a status/control word and a data word. The other two belong to the transmit channel, in the same pairing. The processor can poll the Ready flags, or it can enable an interrupt per channel and let the block request service.

The registers are not a plain store. Reading the receive data word consumes the character and clears its Ready flag. Writing the transmit data word hands a character to the display side and clears its Ready flag. The display handshake sets that flag again. A character that arrives before the previous one has been read replaces it and leaves a sticky overrun mark.

The bus is single-cycle. Read data is a combinational function of the address and the current state. Write effects and read side effects take place at the clock edge that ends the access.

Top module: `console_mmio`

## Requirements
- R1: Decoding uses the word offsets base+0 (receive control), base+4 (receive data), base+8 (transmit control) and base+12 (transmit data). Any other address, including an address that is not word-aligned, reads 0 and changes no state.
- R2: The layout of the control word is: bit 0 Ready, bit 1 interrupt enable, bit 2 overrun (receive channel only). Every other bit reads 0.
- R3: A cycle with `kb_valid` high stores `kb_char` and sets receive Ready. A read of receive data returns the stored byte in bits 7:0 with zeros above, and clears receive Ready at that edge.
- R4: A character that arrives while receive Ready is 1, and that edge is not a receive-data read, overwrites the stored byte and sets overrun. A read of receive control clears overrun. A character that arrives in the same cycle as a receive-data read leaves Ready at 1 and does not set overrun.
- R5: A write to transmit data while transmit Ready is 1 latches bits 7:0 and clears Ready. `disp_valid` then stays high with `disp_char` unchanged until `disp_ready` is seen.
- R6: A cycle with `disp_valid` and `disp_ready` both high completes the transfer. On the next cycle transmit Ready is 1 and `disp_valid` is 0.
- R7: A write to transmit data while transmit Ready is 0 has no effect.
- R8: A write to a control register sets the interrupt enable from bit 1. Written values of bits 0 and 2 are ignored.
- R9: `irq` is high exactly when (receive Ready and receive enable) or (transmit Ready and transmit enable).
- R10: After reset, every flag and enable is 0, except transmit Ready, which is 1. Transmit data reads 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| kb_valid | input | 1 | Keyboard character present this cycle |
| kb_char | input | CHAR_W | Keyboard character |
| disp_valid | output | 1 | Display character offered |
| disp_char | output | CHAR_W | Display character |
| disp_ready | input | 1 | Display accepts the character |
| irq | output | 1 | Level interrupt request |

## Verification
The case hardest to reach from the ports is a keyboard character that lands on the same edge as the processor's receive-data read. The block must hand the old byte to the processor, keep Ready set for the new byte, and not report an overrun. The bench drives `kb_valid` and the read strobe in the same cycle. It checks the returned byte before the edge, and the control word and data word after it. A second race is an out-of-range or misaligned read while a character is pending. The bench shows through the control word that the character was not consumed.

// File: rtl/console_pkg.sv
// Package: register selector and control-word bit positions for the terminal controller.
package console_pkg;
    localparam int CTL_RDY = 0;
    localparam int CTL_IE  = 1;
    localparam int CTL_OVR = 2;

    typedef enum logic [1:0] {
        SEL_RX_CTL = 2'd0,
        SEL_RX_DAT = 2'd1,
        SEL_TX_CTL = 2'd2,
        SEL_TX_DAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/console_decode.sv
// Address decoder: reports a hit for an aligned word inside the 16-byte window at BASE,
// and which of the four words is addressed. Assumes ADDR_W > 4.
module console_decode
    import console_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    // compare the window and alignment, then pick the word index
    always_comb begin
        hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
        sel = reg_sel_e'(addr[3:2]);
    end
endmodule

// File: rtl/console_rx.sv
// Receive channel: holds the last keyboard byte, the Ready flag, the sticky overrun
// flag and the interrupt enable. Assumes the strobes come already qualified by decode.
module console_rx #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_char,
    input  logic              rd_data,
    input  logic              rd_ctrl,
    input  logic              wr_ctrl,
    input  logic              wr_ie,
    output logic              ready,
    output logic              ie,
    output logic              ovr,
    output logic [CHAR_W-1:0] char_q
);
    // state update: enable write, arrival, consumption, overrun set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready  <= 1'b0;
            ie     <= 1'b0;
            ovr    <= 1'b0;
            char_q <= '0;
        end else begin
            if (wr_ctrl) ie <= wr_ie;
            if (rd_ctrl) ovr <= 1'b0;
            if (kb_valid) begin
                char_q <= kb_char;
                ready  <= 1'b1;
                if (ready && !rd_data) ovr <= 1'b1;
            end else if (rd_data) begin
                ready <= 1'b0;
            end
        end
    end

    // R3
    arrive_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> (ready && char_q == $past(kb_char)));
    // R3
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !kb_valid) |=> !ready);
    // R4
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && ready && !rd_data) |=> ovr);
    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !rd_ctrl) |=> ovr);
endmodule

// File: rtl/console_tx.sv
// Transmit channel: accepts a byte when Ready, offers it to the display with a
// valid/ready handshake, and returns to Ready when it is taken. Writes while busy are dropped.
module console_tx #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              wr_ctrl,
    input  logic              wr_ie,
    input  logic              disp_ready,
    output logic              ready,
    output logic              ie,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char
);
    // state update: enable write, hand-off completion, new character load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready     <= 1'b1;
            ie        <= 1'b0;
            disp_char <= '0;
        end else begin
            if (wr_ctrl) ie <= wr_ie;
            if (disp_valid && disp_ready) begin
                ready <= 1'b1;
            end else if (wr_data && ready) begin
                ready     <= 1'b0;
                disp_char <= wr_char;
            end
        end
    end

    // offer the byte whenever the channel is busy
    always_comb disp_valid = !ready;

    // R5
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_char)));
    // R6
    handoff_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (ready && !disp_valid));
    // R5
    load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ready) |=> (disp_valid && disp_char == $past(wr_char)));
endmodule

// File: rtl/console_mmio.sv
// Top: memory-mapped terminal controller. Decodes four word registers, routes
// qualified strobes to the channels, forms read data and the interrupt request.
// Assumes a single-cycle bus: read data is combinational, effects occur at the edge.
module console_mmio
    import console_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter int                DATA_W = 32,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_char,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_ready,
    output logic              irq
);
    logic              hit;
    reg_sel_e          sel;
    logic              rx_ready, rx_ie, rx_ovr, tx_ready, tx_ie;
    logic [CHAR_W-1:0] rx_char;
    logic              rd_rxc, rd_rxd, wr_rxc, wr_txc, wr_txd;
    logic              unused_wdata;

    console_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) i_dec (
        .addr(bus_addr), .hit(hit), .sel(sel)
    );

    // qualify the bus strobes with the decoded register
    always_comb begin
        rd_rxc = bus_rd && hit && (sel == SEL_RX_CTL);
        rd_rxd = bus_rd && hit && (sel == SEL_RX_DAT);
        wr_rxc = bus_wr && hit && (sel == SEL_RX_CTL);
        wr_txc = bus_wr && hit && (sel == SEL_TX_CTL);
        wr_txd = bus_wr && hit && (sel == SEL_TX_DAT);
    end

    console_rx #(.CHAR_W(CHAR_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_char(kb_char),
        .rd_data(rd_rxd), .rd_ctrl(rd_rxc), .wr_ctrl(wr_rxc),
        .wr_ie(bus_wdata[CTL_IE]), .ready(rx_ready), .ie(rx_ie),
        .ovr(rx_ovr), .char_q(rx_char)
    );

    console_tx #(.CHAR_W(CHAR_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_txd),
        .wr_char(bus_wdata[CHAR_W-1:0]), .wr_ctrl(wr_txc),
        .wr_ie(bus_wdata[CTL_IE]), .disp_ready(disp_ready),
        .ready(tx_ready), .ie(tx_ie), .disp_valid(disp_valid),
        .disp_char(disp_char)
    );

    // read mux: the addressed word, zero outside the window
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_RX_CTL: begin
                    bus_rdata[CTL_RDY] = rx_ready;
                    bus_rdata[CTL_IE]  = rx_ie;
                    bus_rdata[CTL_OVR] = rx_ovr;
                end
                SEL_RX_DAT: bus_rdata[CHAR_W-1:0] = rx_char;
                SEL_TX_CTL: begin
                    bus_rdata[CTL_RDY] = tx_ready;
                    bus_rdata[CTL_IE]  = tx_ie;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // interrupt request from either enabled, ready channel
    always_comb irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);

    assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

    // R1
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_rdata == '0));
    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
    // R9
    irq_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !tx_ready) |-> !irq);
    // R2
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (sel == SEL_TX_CTL)) |-> (bus_rdata[DATA_W-1:CTL_OVR] == '0));
endmodule

// File: tb/test_console_mmio.sv
module test_console_mmio;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_KB = 2'd2, K_DSP = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  off;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{K_RD,  8'd0,  32'h0,          32'h0,  4'd10}, // R10 rx ctl after reset
        '{K_RD,  8'd8,  32'h0,          32'h1,  4'd10}, // R10 tx ready after reset
        '{K_KB,  8'd0,  32'h41,         32'h0,  4'd3 }, // R3 arrival
        '{K_RD,  8'd0,  32'h0,          32'h1,  4'd3 }, // R3 ready set
        '{K_RD,  8'd4,  32'h0,          32'h41, 4'd3 }, // R3 data, upper zero
        '{K_RD,  8'd0,  32'h0,          32'h0,  4'd3 }, // R3 ready cleared
        '{K_KB,  8'd0,  32'h42,         32'h0,  4'd4 },
        '{K_KB,  8'd0,  32'h43,         32'h0,  4'd4 }, // R4 overrun arrival
        '{K_RD,  8'd0,  32'h0,          32'h5,  4'd4 }, // R4 overrun flagged
        '{K_RD,  8'd0,  32'h0,          32'h1,  4'd4 }, // R4 cleared by read
        '{K_RD,  8'd4,  32'h0,          32'h43, 4'd4 }, // R4 overwritten
        '{K_WR,  8'd0,  32'hFFFF_FFFF,  32'h0,  4'd8 },
        '{K_RD,  8'd0,  32'h0,          32'h2,  4'd8 }, // R8 only IE taken, R2
        '{K_WR,  8'd12, 32'h1234_5A7E,  32'h0,  4'd5 },
        '{K_RD,  8'd8,  32'h0,          32'h0,  4'd5 }, // R5 tx ready cleared
        '{K_WR,  8'd12, 32'h0000_0011,  32'h0,  4'd7 }, // R7 dropped write
        '{K_DSP, 8'd0,  32'h0,          32'h7E, 4'd5 }, // R5 held byte, R7
        '{K_RD,  8'd8,  32'h0,          32'h1,  4'd6 }, // R6 ready again
        '{K_WR,  8'd0,  32'h0,          32'h0,  4'd8 },
        '{K_RD,  8'd12, 32'h0,          32'h0,  4'd10}  // R10 tx data reads 0
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, kb_valid, disp_valid, disp_ready, irq;
    logic [7:0]  kb_char, disp_char;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    console_mmio i_console_mmio (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_char(kb_char), .disp_valid(disp_valid),
        .disp_char(disp_char), .disp_ready(disp_ready), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // finish the current access: edge, release strobes, move to mid-low phase
    task automatic finish_cycle();
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; kb_valid = 0; disp_ready = 0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [31:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_rd = 1;
        #1 check(bus_rdata, exp, req);
        finish_cycle();
    endtask

    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        finish_cycle();
    endtask

    task automatic do_kb(input logic [7:0] c);
        kb_char = c; kb_valid = 1;
        finish_cycle();
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
        kb_valid = 0; kb_char = 0; disp_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 outputs during reset
        check({31'b0, irq}, 32'h0, "R10 irq");
        check({31'b0, disp_valid}, 32'h0, "R10 disp_valid");
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            case (TBL[i].kind)
                K_WR:  do_wr(BASE + TBL[i].off, TBL[i].data);
                K_RD:  do_rd(BASE + TBL[i].off, TBL[i].exp, tag);
                K_KB:  do_kb(TBL[i].data[7:0]);
                default: begin
                    disp_ready = 1;
                    #1 check({23'b0, disp_valid, disp_char}, {23'b0, 1'b1, TBL[i].exp[7:0]}, tag);
                    finish_cycle();
                end
            endcase
        end

        // R9 receive interrupt follows ready and enable
        do_wr(BASE + 0, 32'h2);
        check({31'b0, irq}, 32'h0, "R9 enabled but not ready");
        do_kb(8'h55);
        check({31'b0, irq}, 32'h1, "R9 rx request");
        do_rd(BASE + 4, 32'h55, "R9 rx data");
        check({31'b0, irq}, 32'h0, "R9 rx request dropped");
        do_wr(BASE + 8, 32'h3);
        check({31'b0, irq}, 32'h1, "R9 tx request");
        do_wr(BASE + 8, 32'h0);
        do_wr(BASE + 0, 32'h0);
        check({31'b0, irq}, 32'h0, "R9 both disabled");

        // R1 miss and misaligned reads leave a pending character in place
        do_kb(8'h60);
        do_rd(32'hFFFE_0004, 32'h0, "R1 window miss");
        do_rd(BASE + 5, 32'h0, "R1 misaligned");
        do_rd(BASE + 16, 32'h0, "R1 past end");
        do_wr(BASE + 17, 32'h2);
        do_rd(BASE + 0, 32'h1, "R1 no side effect");

        // R4 arrival on the same edge as a data read
        bus_addr = BASE + 4; bus_rd = 1; kb_char = 8'h61; kb_valid = 1;
        #1 check(bus_rdata, 32'h60, "R4 same-cycle old byte");
        finish_cycle();
        do_rd(BASE + 0, 32'h1, "R4 same-cycle ready, no overrun");
        do_rd(BASE + 4, 32'h61, "R4 same-cycle new byte");

        // R10 reset mid-transfer restores defaults
        do_wr(BASE + 12, 32'h99);
        do_wr(BASE + 0, 32'h2);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check({31'b0, disp_valid}, 32'h0, "R10 valid after reset");
        do_rd(BASE + 8, 32'h1, "R10 tx ready after reset");
        do_rd(BASE + 0, 32'h0, "R10 rx cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule